// File: doc/BRIEF.md
# Message Bus Target Receiver

This block is the receiving end of a node attached to a shared 32-bit synchronous message bus. An initiator frames each message with an active-low envelope strobe. The receiver finds the start of a message on the falling edge of that strobe and reads the first qualified word as a header. The header decides whether this node takes the message. After that the receiver passes the words it accepts to a local buffer as a marked stream. The initiator may insert wait states by lowering its ready line, and the receiver ignores every bus pin in those cycles.

A header carries a destination bitmap, a broadcast flag and a type flag. The type flag separates frame-data messages from command messages. A frame-data message ends with a status word, and the initiator marks that word by pulling end-of-frame low. The receiver tags this word on the output. If the local buffer refuses a word, the receiver pulls its active-low abort output and drops everything until the envelope ends. Each accepted message closes with one result pulse, which reports a clean finish, an abort or a truncated frame.

Top module: `msgbus_rx`

## Requirements
- R1: During and right after synchronous reset, `word_valid`, `word_first`, `word_status` and `done_valid` are low and `abort_n` is high.
- R2: A message starts only when `env_n` is low in a cycle after a cycle in which it was high. If `env_n` is already low when reset is released, the receiver ignores all bus activity until `env_n` has been high for at least one cycle.
- R3: The header is the first word after a start that is sampled with `irdy` high. Bit 31 is the broadcast flag, bit 30 set marks a frame-data message, and bits [NODES-1:0] are the destination bitmap. The node accepts the message when bit 31 is set or when bit NODE_ID is set. An accepted header is forwarded with `word_first` high.
- R4: For a message that is not accepted, the receiver emits no words, gives no result pulse and keeps `abort_n` high.
- R5: A cycle with `irdy` low is ignored completely: `bus_data`, `eof_n` and `buf_ready` have no effect in that cycle.
- R6: In an accepted frame-data message, a qualified non-header word sampled with `eof_n` low is forwarded with `word_status` high. Qualified words after that word are dropped. In command messages, and on any header, `eof_n` is ignored.
- R7: Each accepted word appears on `word_data`, with `word_valid` high, in the cycle after the clock edge that sampled it.
- R8: If a qualified word that would be forwarded meets `buf_ready` low, that word is dropped and `abort_n` goes low from the next cycle. `abort_n` stays low until the cycle after `env_n` is sampled high, and no further words are forwarded in between.
- R9: For an accepted message, the cycle after `env_n` is first sampled high carries a one-cycle `done_valid` pulse with `done_code`. The code is 1 if the message was aborted. Otherwise it is 2 if the message was a frame-data message that ended without an end-of-frame word. Otherwise it is 0.
- R10: If the envelope ends before any header has been sampled, no result pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 32 | Shared data bus |
| env_n | input | 1 | Message envelope, active low |
| eof_n | input | 1 | End-of-frame marker, active low |
| irdy | input | 1 | Initiator ready; qualifies the data word |
| buf_ready | input | 1 | Local buffer can take a word |
| abort_n | output | 1 | Target abort, active low |
| word_valid | output | 1 | Forwarded word is present |
| word_data | output | 32 | Forwarded word |
| word_first | output | 1 | Forwarded word is the header |
| word_status | output | 1 | Forwarded word is the frame status word |
| done_valid | output | 1 | One-cycle result pulse |
| done_code | output | 2 | 0 clean, 1 aborted, 2 truncated |

## Verification
The assertions check local cycle relations on every cycle. A forwarded word must trace back to a sampled cycle with envelope low, ready high and buffer ready. A status tag needs a sampled end-of-frame, abort may fall only on a refused qualified word, and a result pulse needs a deasserted envelope and never overlaps a word. Other properties depend on the whole message and can only be shown by the bench's scenarios. These are header address matching, dropping after a status word or an abort, the priority among result codes, ignoring an envelope held low through reset, and envelopes that end without a header.

// File: rtl/msgbus_rx_pkg.sv
package msgbus_rx_pkg;

    localparam int BUS_W      = 32;
    localparam int BCAST_BIT  = BUS_W - 1;
    localparam int FRAME_BIT  = BUS_W - 2;
    localparam int CODE_W     = 2;

    typedef logic [BUS_W-1:0] bus_word_t;

    typedef enum logic [CODE_W-1:0] {
        DONE_CLEAN = 2'd0,
        DONE_ABORT = 2'd1,
        DONE_TRUNC = 2'd2
    } done_code_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_WAIT_HDR,
        RX_TAKE,
        RX_SKIP,
        RX_ABORTED
    } rx_state_e;

    typedef struct packed {
        logic hit;
        logic frame;
    } hdr_info_t;

    typedef struct packed {
        logic      valid;
        logic      first;
        logic      status;
        bus_word_t data;
    } out_word_t;

    function automatic done_code_e pick_code(logic aborted, logic frame, logic eof_seen);
        if (aborted)
            return DONE_ABORT;
        else if (frame && !eof_seen)
            return DONE_TRUNC;
        else
            return DONE_CLEAN;
    endfunction

endpackage

// File: rtl/msgbus_env_track.sv
module msgbus_env_track (
    input  logic clk,
    input  logic rst,
    input  logic env_n,
    output logic start
);
    // was the envelope asserted in the previous sampled cycle; reset to
    // "asserted" so an envelope already low at reset release is not a start
    logic was_on_q;

    always_ff @(posedge clk) begin
        if (rst)
            was_on_q <= 1'b1;
        else
            was_on_q <= !env_n;
    end

    assign start = !env_n && !was_on_q;

endmodule

// File: rtl/msgbus_hdr_decode.sv
module msgbus_hdr_decode
    import msgbus_rx_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int NODE_ID = 5
) (
    input  bus_word_t word,
    output hdr_info_t info
);
    logic own_bit;

    generate
        if (NODE_ID >= 0 && NODE_ID < NODES && NODE_ID < FRAME_BIT) begin : g_map
            assign own_bit = word[NODE_ID];
        end else begin : g_nomap
            assign own_bit = 1'b0;
        end
    endgenerate

    assign info.hit   = word[BCAST_BIT] | own_bit;
    assign info.frame = word[FRAME_BIT];

endmodule

// File: rtl/msgbus_rx_ctrl.sv
module msgbus_rx_ctrl
    import msgbus_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       env_n,
    input  logic       irdy,
    input  logic       eof_n,
    input  logic       buf_ready,
    input  bus_word_t  bus_data,
    input  hdr_info_t  info,
    output out_word_t  out_q,
    output logic       abort_n_q,
    output logic       done_valid_q,
    output done_code_e done_code_q
);
    rx_state_e state_q, state_d;
    logic      frame_q, frame_d;
    logic      eof_seen_q, eof_seen_d;
    logic      take_hdr;
    out_word_t out_d;
    logic      done_v_d;
    done_code_e done_c_d;

    always_comb begin
        state_d    = state_q;
        frame_d    = frame_q;
        eof_seen_d = eof_seen_q;
        take_hdr   = 1'b0;
        out_d      = '{valid: 1'b0, first: 1'b0, status: 1'b0, data: bus_data};
        done_v_d   = 1'b0;
        done_c_d   = DONE_CLEAN;

        unique case (state_q)
            RX_IDLE: begin
                if (start) begin
                    if (irdy) take_hdr = 1'b1;
                    else      state_d  = RX_WAIT_HDR;
                end
            end
            RX_WAIT_HDR: begin
                if (env_n)     state_d  = RX_IDLE;
                else if (irdy) take_hdr = 1'b1;
            end
            RX_TAKE: begin
                if (env_n) begin
                    done_v_d = 1'b1;
                    done_c_d = pick_code(1'b0, frame_q, eof_seen_q);
                    state_d  = RX_IDLE;
                end else if (irdy && !(frame_q && eof_seen_q)) begin
                    if (buf_ready) begin
                        out_d.valid  = 1'b1;
                        out_d.status = frame_q && !eof_n;
                        eof_seen_d   = frame_q && !eof_n;
                    end else begin
                        state_d = RX_ABORTED;
                    end
                end
            end
            RX_SKIP: begin
                if (env_n) state_d = RX_IDLE;
            end
            RX_ABORTED: begin
                if (env_n) begin
                    done_v_d = 1'b1;
                    done_c_d = pick_code(1'b1, frame_q, eof_seen_q);
                    state_d  = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase

        if (take_hdr) begin
            frame_d    = info.frame;
            eof_seen_d = 1'b0;
            if (!info.hit) begin
                state_d = RX_SKIP;
            end else if (buf_ready) begin
                out_d.valid = 1'b1;
                out_d.first = 1'b1;
                state_d     = RX_TAKE;
            end else begin
                state_d = RX_ABORTED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= RX_IDLE;
            frame_q      <= 1'b0;
            eof_seen_q   <= 1'b0;
            out_q        <= '0;
            abort_n_q    <= 1'b1;
            done_valid_q <= 1'b0;
            done_code_q  <= DONE_CLEAN;
        end else begin
            state_q      <= state_d;
            frame_q      <= frame_d;
            eof_seen_q   <= eof_seen_d;
            out_q.valid  <= out_d.valid;
            out_q.first  <= out_d.first;
            out_q.status <= out_d.status;
            if (out_d.valid)
                out_q.data <= out_d.data;
            abort_n_q    <= (state_d != RX_ABORTED);
            done_valid_q <= done_v_d;
            done_code_q  <= done_c_d;
        end
    end

endmodule

// File: rtl/msgbus_rx.sv
module msgbus_rx
    import msgbus_rx_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int NODE_ID = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              env_n,
    input  logic              eof_n,
    input  logic              irdy,
    input  logic              buf_ready,
    output logic              abort_n,
    output logic              word_valid,
    output logic [BUS_W-1:0]  word_data,
    output logic              word_first,
    output logic              word_status,
    output logic              done_valid,
    output logic [CODE_W-1:0] done_code
);
    logic       start;
    hdr_info_t  info;
    out_word_t  out_q;
    done_code_e code_q;

    msgbus_env_track u_env (
        .clk   (clk),
        .rst   (rst),
        .env_n (env_n),
        .start (start)
    );

    msgbus_hdr_decode #(
        .NODES   (NODES),
        .NODE_ID (NODE_ID)
    ) u_hdr (
        .word (bus_data),
        .info (info)
    );

    msgbus_rx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .env_n        (env_n),
        .irdy         (irdy),
        .eof_n        (eof_n),
        .buf_ready    (buf_ready),
        .bus_data     (bus_data),
        .info         (info),
        .out_q        (out_q),
        .abort_n_q    (abort_n),
        .done_valid_q (done_valid),
        .done_code_q  (code_q)
    );

    assign word_valid  = out_q.valid;
    assign word_data   = out_q.data;
    assign word_first  = out_q.first;
    assign word_status = out_q.status;
    assign done_code   = code_q;

endmodule

// File: rtl/msgbus_rx_chk.sv
module msgbus_rx_chk (
    input logic clk,
    input logic rst,
    input logic env_n,
    input logic eof_n,
    input logic irdy,
    input logic buf_ready,
    input logic abort_n,
    input logic word_valid,
    input logic word_first,
    input logic word_status,
    input logic done_valid,
    input logic [1:0] done_code
);
    // R7
    word_src_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(irdy) && !$past(env_n) && $past(buf_ready)));

    // R6
    status_src_chk: assert property (@(posedge clk) disable iff (rst)
        word_status |-> (word_valid && !word_first && !$past(eof_n)));

    // R8
    abort_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(abort_n) |-> ($past(irdy) && !$past(buf_ready) && !$past(env_n)));

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !abort_n |-> !word_valid);

    // R9
    done_env_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> ($past(env_n) && !word_valid && done_code != 2'd3));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!word_valid && !done_valid && abort_n));

endmodule

bind msgbus_rx msgbus_rx_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .env_n       (env_n),
    .eof_n       (eof_n),
    .irdy        (irdy),
    .buf_ready   (buf_ready),
    .abort_n     (abort_n),
    .word_valid  (word_valid),
    .word_first  (word_first),
    .word_status (word_status),
    .done_valid  (done_valid),
    .done_code   (done_code)
);

// File: tb/msgbus_rx_tb_top.sv
`timescale 1ns/1ps
module msgbus_rx_tb_top;

    localparam int TB_NODES = 16;
    localparam int TB_ID    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_data = '0;
    logic        env_n = 1'b1;
    logic        eof_n = 1'b1;
    logic        irdy = 1'b0;
    logic        buf_ready = 1'b1;
    logic        abort_n;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_first;
    logic        word_status;
    logic        done_valid;
    logic [1:0]  done_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    msgbus_rx #(.NODES(TB_NODES), .NODE_ID(TB_ID)) dut_i (
        .clk(clk), .rst(rst), .bus_data(bus_data), .env_n(env_n), .eof_n(eof_n),
        .irdy(irdy), .buf_ready(buf_ready), .abort_n(abort_n),
        .word_valid(word_valid), .word_data(word_data), .word_first(word_first),
        .word_status(word_status), .done_valid(done_valid), .done_code(done_code)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_hit(logic [31:0] h);
        return h[31] | h[TB_ID];
    endfunction

    function automatic logic [1:0] exp_code(bit ab, bit fr, bit eof_seen);
        if (ab) return 2'd1;
        if (fr && !eof_seen) return 2'd2;
        return 2'd0;
    endfunction

    // envelope-high cycle that closes a message
    task automatic close_msg(bit acc, bit ab, bit fr, bit eof_seen, string req);
        env_n = 1'b1; eof_n = 1'b1;
        irdy = 1'($urandom); buf_ready = 1'($urandom); bus_data = $urandom;
        @(negedge clk);
        chk(req, "done_valid", done_valid, acc);
        if (acc) chk("R9", "done_code", done_code, exp_code(ab, fr, eof_seen));
        chk("R8", "abort_n release", abort_n, 1'b1);
        chk("R4", "no word at close", word_valid, 1'b0);
    endtask

    // hdr, nw payload words, eof on word nw if give_eof, extra words after,
    // stall = qualified word index meeting buf_ready low (-1 none)
    task automatic send_msg(logic [31:0] hdr, int nw, bit give_eof, int extra,
                            int stall, int wait_pct);
        bit acc = is_hit(hdr);
        bit fr = hdr[30];
        bit ab = 0;
        bit eof_seen = 0;
        int total = 1 + nw + extra;
        for (int i = 0; i < total; i++) begin
            bit eof_now;
            bit exp_v;
            bit exp_s;
            logic [31:0] w;
            while (int'($urandom_range(99)) < wait_pct) begin
                env_n = 1'b0; irdy = 1'b0; eof_n = 1'($urandom);
                buf_ready = 1'($urandom); bus_data = $urandom;
                @(negedge clk);
                chk("R5", "wait state word_valid", word_valid, 1'b0);
                chk("R5", "wait state abort_n", abort_n, !ab);
            end
            w = (i == 0) ? hdr : $urandom;
            eof_now = give_eof && (i == nw) && (nw > 0);
            env_n = 1'b0; irdy = 1'b1; bus_data = w; eof_n = !eof_now;
            buf_ready = (i != stall);
            exp_v = 0; exp_s = 0;
            if (acc && !ab && !(fr && eof_seen)) begin
                if (i != stall) begin
                    exp_v = 1;
                    exp_s = fr && (i > 0) && eof_now;
                    if (exp_s) eof_seen = 1;
                end else begin
                    ab = 1;
                end
            end
            @(negedge clk);
            chk(acc ? "R7" : "R4", "word_valid", word_valid, exp_v);
            if (exp_v) begin
                chk("R7", "word_data", word_data, w);
                chk("R3", "word_first", word_first, i == 0);
                chk("R6", "word_status", word_status, exp_s);
            end
            chk("R8", "abort_n", abort_n, !ab);
        end
        close_msg(acc, ab, fr, eof_seen, acc ? "R9" : "R4");
    endtask

    function automatic logic [31:0] make_hdr(int kind, bit fr);
        logic [31:0] h = $urandom;
        h[30] = fr;
        case (kind)
            0: begin h[31] = 0; h[TB_ID] = 1; end
            1: begin h[31] = 1; end
            default: begin h[31] = 0; h[TB_ID] = 0; end
        endcase
        return h;
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // envelope held low across reset release: R2
        env_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset word_valid", word_valid, 1'b0);
        chk("R1", "reset done_valid", done_valid, 1'b0);
        chk("R1", "reset abort_n", abort_n, 1'b1);
        chk("R1", "reset word_first", word_first, 1'b0);
        chk("R1", "reset word_status", word_status, 1'b0);
        for (int i = 0; i < 4; i++) begin
            irdy = 1'b1; bus_data = make_hdr(1, 1'b0); buf_ready = (i != 2);
            @(negedge clk);
            chk("R2", "mid-message word_valid", word_valid, 1'b0);
            chk("R2", "mid-message abort_n", abort_n, 1'b1);
        end
        close_msg(1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // directed corner cases
        send_msg(make_hdr(0, 1'b1), 3, 1'b1, 0, -1, 0);   // R6 clean frame
        send_msg(make_hdr(0, 1'b1), 3, 1'b0, 0, -1, 0);   // R9 truncated
        send_msg(make_hdr(1, 1'b1), 2, 1'b1, 2, -1, 0);   // R6 words after eof dropped
        send_msg(make_hdr(1, 1'b1), 2, 1'b1, 2, 3, 0);    // R6 stall after eof ignored
        send_msg(make_hdr(0, 1'b0), 3, 1'b1, 1, -1, 0);   // R6 eof ignored on command
        send_msg(make_hdr(0, 1'b1), 4, 1'b1, 0, 0, 0);    // R8 header refused
        send_msg(make_hdr(0, 1'b1), 4, 1'b1, 0, 2, 40);   // R8 abort mid-frame
        send_msg(make_hdr(2, 1'b1), 3, 1'b1, 0, 1, 40);   // R4 not addressed
        send_msg(make_hdr(0, 1'b0), 0, 1'b0, 0, -1, 60);  // R3 header only

        // R10: envelope without any qualified word
        env_n = 1'b0; irdy = 1'b0; bus_data = make_hdr(1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R10", "no header word_valid", word_valid, 1'b0);
        close_msg(1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // constrained random messages
        for (int m = 0; m < 150; m++) begin
            int kind = $urandom_range(3);
            bit fr = 1'($urandom);
            int nw = $urandom_range(6);
            bit ge = ($urandom_range(3) != 0);
            int ex = ($urandom_range(4) == 0) ? 1 : 0;
            int st = ($urandom_range(3) == 0) ? int'($urandom_range(nw + ex)) : -1;
            send_msg(make_hdr(kind, fr), nw, ge, ex, st, $urandom_range(50));
            if ($urandom_range(2) == 0) begin
                env_n = 1'b1; irdy = 1'($urandom); bus_data = $urandom;
                @(negedge clk);
                chk("R9", "idle done_valid", done_valid, 1'b0);
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule